// File: doc/BRIEF.md
# Selectable A-law / µ-law PCM Compander

This block converts between 14-bit two's-complement linear audio samples and 8-bit companded PCM words in both directions at once. On each cycle where `in_valid` is high, it encodes `lin_in` into a PCM word and decodes `pcm_in` into a linear sample. Both results appear on registered outputs one clock later.

Two mode bits are sampled together with the strobe. `law_a` chooses A-law (1) or µ-law (0). `fmt_sm` chooses the plain sign/magnitude word (1) or the standard CCITT G.711 word (0). Both directions use the same mode bits, so a value that is encoded and then decoded comes back through the same code map.

Control is a two-state machine. In `ST_IDLE` no result is presented. In `ST_LOADED` a fresh result is on the outputs. The transitions are:
- `T_CAPTURE` (`ST_IDLE` to `ST_LOADED`) when the strobe is high.
- `T_RELOAD` (`ST_LOADED` to `ST_LOADED`) when the strobe is high.
- `T_DRAIN` (`ST_LOADED` to `ST_IDLE`) when the strobe is low.
- `T_WAIT` (`ST_IDLE` to `ST_IDLE`) when the strobe is low.

Top module: `g711_codec`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `pcm_out` and `lin_out` are all 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and low after a cycle with `in_valid` low. `pcm_out` and `lin_out` change only on a strobed cycle and otherwise hold their last values.
- R3: Sign/magnitude word layout:
  - Bit 7 is the sign (1 = non-negative), bits 6:4 are the segment and bits 3:0 are the step.
  - The codes are 0xFF = positive full scale, 0x80 = positive zero, 0x00 = negative zero and 0x7F = negative full scale.
  - With `fmt_sm`=1, µ-law 0 encodes to 0x80 and 8191 encodes to 0xFF. A-law -1 encodes to 0x00 and -8192 encodes to 0x7F.
- R4: The µ-law CCITT word is the sign/magnitude word XOR 0x7F:
  - 0 encodes to 0xFF.
  - 8191 encodes to 0x80.
  - -8192 encodes to 0x00.
- R5: The A-law CCITT word is the sign/magnitude word XOR 0x55:
  - 0 encodes to 0xD5.
  - -1 encodes to 0x55.
  - 8191 encodes to 0xAA.
  - -8192 encodes to 0x2A.
- R6: µ-law encode:
  - Take m = |x|, clip it to 8158 and add 33 to get b.
  - The segment is the position of the leading one of b minus 5.
  - The step is the four bits of b just below the leading one.
- R7: A-law encode:
  - Take a = x >>> 1. The magnitude is a when a >= 0 and -a-1 otherwise.
  - If the magnitude is below 32, the segment is 0 and the step is magnitude[4:1].
  - Otherwise the segment is the leading-one position minus 4 and the step is the four bits below the leading one.
- R8: A µ-law input above +8158 or below -8158 encodes to full scale of its sign (sign/magnitude 0xFF or 0x7F).
- R9: µ-law decode gives ±(((2·step+33) << segment) − 33), negative when bit 7 of the sign/magnitude word is 0.
- R10: A-law decode gives ±2·M:
  - M = 2·step+1 for segment 0.
  - Otherwise M = (2·step+33) << (segment−1).
- R11: µ-law zero codes decode to exactly 0. A-law positive and negative zero codes decode to +2 and −2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; captures both conversions and the mode |
| law_a | input | 1 | 1 = A-law, 0 = µ-law |
| fmt_sm | input | 1 | 1 = sign/magnitude word, 0 = CCITT word |
| lin_in | input | 14 | Linear sample to encode (two's complement) |
| pcm_in | input | 8 | PCM word to decode |
| out_valid | output | 1 | High while a registered result is presented |
| pcm_out | output | 8 | Encoded PCM word |
| lin_out | output | 14 | Decoded linear sample (two's complement) |

## Verification
The clocked properties assume that the mode bits and data inputs are meaningful only in a cycle where `in_valid` is high. They also assume that `law_a` and `fmt_sm` arrive in that same cycle, not a cycle earlier. The bench therefore drives the strobe, the mode bits and both data words together on the falling edge, so each strobed cycle carries a complete, self-consistent request. Idle gaps still drive arbitrary data words with the strobe low. This shows that unstrobed data never reaches the outputs.

// File: rtl/g711_pkg.sv
package g711_pkg;
    localparam int LIN_W    = 14;
    localparam int PCM_W    = 8;
    localparam int SEG_W    = 3;
    localparam int STEP_W   = 4;
    localparam int MAG_W    = LIN_W - 1;
    localparam int SEG_N    = 1 << SEG_W;
    localparam int MU_BIAS  = 33;
    localparam int MU_CLIP  = (1 << MAG_W) - 1 - MU_BIAS;
    localparam int A_BASE   = 33;
    localparam int DEC_MAX  = ((2 * ((1 << STEP_W) - 1)) + MU_BIAS) << (SEG_N - 1);
    localparam logic [PCM_W-1:0] MU_MASK = 8'h7F;
    localparam logic [PCM_W-1:0] A_MASK  = 8'h55;

    typedef struct packed {
        logic              pos;
        logic [SEG_W-1:0]  seg;
        logic [STEP_W-1:0] step;
    } sm_code_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/g711_format.sv
module g711_format
    import g711_pkg::*;
(
    input  logic [PCM_W-1:0] din,
    input  logic             law_a,
    input  logic             fmt_sm,
    output logic [PCM_W-1:0] dout
);
    logic [PCM_W-1:0] mask;

    // Sign/magnitude passes straight; CCITT flips a per-law bit pattern (R4, R5).
    always_comb begin
        if (fmt_sm)     mask = '0;
        else if (law_a) mask = A_MASK;
        else            mask = MU_MASK;
    end

    assign dout = din ^ mask;
endmodule

// File: rtl/g711_encoder.sv
module g711_encoder
    import g711_pkg::*;
(
    input  logic [LIN_W-1:0] lin,
    input  logic             law_a,
    output sm_code_t         code
);
    logic              neg;
    logic [LIN_W-1:0]  mu_abs;
    logic [MAG_W-1:0]  mu_bias;
    logic [SEG_W-1:0]  mu_seg;
    logic [STEP_W-1:0] mu_step;
    logic [MAG_W-2:0]  a_mag;
    logic [SEG_W-1:0]  a_seg;
    logic [SEG_W:0]    a_base;
    logic [STEP_W-1:0] a_step;
    logic              unused_lsb;

    assign neg    = lin[LIN_W-1];
    assign mu_abs = neg ? (~lin + LIN_W'(1)) : lin;

    // mu-law: clip then bias (R6, R8)
    assign mu_bias = ((mu_abs > LIN_W'(MU_CLIP)) ? MAG_W'(MU_CLIP) : mu_abs[MAG_W-1:0])
                     + MAG_W'(MU_BIAS);

    always_comb begin
        mu_seg = '0;
        for (int i = 1; i < SEG_N; i++) begin
            if (mu_bias[i+5]) mu_seg = SEG_W'(i);
        end
    end

    assign mu_step = mu_bias[({1'b0, mu_seg} + 4'd1) +: STEP_W];

    always_comb begin
        AST_MU_BIAS_FLOOR: assert (mu_bias >= MAG_W'(MU_BIAS)); // R6
    end

    // A-law: halve, one's-complement magnitude (R7)
    assign a_mag = neg ? ~lin[MAG_W-1:1] : lin[MAG_W-1:1];

    always_comb begin
        a_seg = '0;
        for (int i = 1; i < SEG_N; i++) begin
            if (a_mag[i+4]) a_seg = SEG_W'(i);
        end
    end

    assign a_base = (a_seg == '0) ? 4'd1 : {1'b0, a_seg};
    assign a_step = a_mag[a_base +: STEP_W];

    assign unused_lsb = mu_bias[0] ^ a_mag[0];

    always_comb begin
        code.pos  = ~neg;
        code.seg  = law_a ? a_seg  : mu_seg;
        code.step = law_a ? a_step : mu_step;
    end
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
    import g711_pkg::*;
(
    input  sm_code_t         code,
    input  logic             law_a,
    output logic [LIN_W-1:0] lin
);
    logic [MAG_W-1:0] mu_mid;
    logic [MAG_W-1:0] mu_mag;
    logic [MAG_W-2:0] a_half;
    logic [MAG_W-1:0] mag;

    // mu-law mid-step reconstruction (R9)
    assign mu_mid = (MAG_W'({code.step, 1'b0}) + MAG_W'(MU_BIAS)) << code.seg;
    assign mu_mag = mu_mid - MAG_W'(MU_BIAS);

    // A-law mid-step reconstruction on the halved scale (R10)
    always_comb begin
        if (code.seg == '0)
            a_half = (MAG_W-1)'({code.step, 1'b1});
        else
            a_half = ((MAG_W-1)'({code.step, 1'b0}) + (MAG_W-1)'(A_BASE)) << (code.seg - 3'd1);
    end

    assign mag = law_a ? {a_half, 1'b0} : mu_mag;
    assign lin = code.pos ? {1'b0, mag} : (~{1'b0, mag} + LIN_W'(1));

    always_comb begin
        AST_DEC_RANGE: assert (mag <= MAG_W'(DEC_MAX)); // R9
    end
endmodule

// File: rtl/g711_codec.sv
module g711_codec
    import g711_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             law_a,
    input  logic             fmt_sm,
    input  logic [LIN_W-1:0] lin_in,
    input  logic [PCM_W-1:0] pcm_in,
    output logic             out_valid,
    output logic [PCM_W-1:0] pcm_out,
    output logic [LIN_W-1:0] lin_out
);
    ctl_state_t       state_q, state_d;
    sm_code_t         enc_code;
    sm_code_t         dec_code;
    logic [PCM_W-1:0] enc_word;
    logic [PCM_W-1:0] dec_word;
    logic [LIN_W-1:0] dec_lin;

    g711_encoder u_enc (
        .lin   (lin_in),
        .law_a (law_a),
        .code  (enc_code)
    );

    g711_format u_fmt_out (
        .din    (enc_code),
        .law_a  (law_a),
        .fmt_sm (fmt_sm),
        .dout   (enc_word)
    );

    g711_format u_fmt_in (
        .din    (pcm_in),
        .law_a  (law_a),
        .fmt_sm (fmt_sm),
        .dout   (dec_word)
    );

    assign dec_code = sm_code_t'(dec_word);

    g711_decoder u_dec (
        .code  (dec_code),
        .law_a (law_a),
        .lin   (dec_lin)
    );

    // next-state: T_CAPTURE, T_RELOAD, T_DRAIN, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers (R1, R2)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_out <= '0;
            lin_out <= '0;
        end else if (in_valid) begin
            pcm_out <= enc_word;
            lin_out <= dec_lin;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pcm_out) && $stable(lin_out))); // R2
    AST_MU_SAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !law_a && fmt_sm && ($signed(lin_in) > 14'sd8158)) |=> (pcm_out == 8'hFF)); // R8
    AST_MU_SAT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !law_a && fmt_sm && ($signed(lin_in) < -14'sd8158)) |=> (pcm_out == 8'h7F)); // R8
    AST_MU_ZERO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !law_a && fmt_sm && (pcm_in[6:0] == 7'd0)) |=> (lin_out == '0)); // R11
endmodule

// File: tb/g711_codec_bench.sv
module g711_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        law_a;
    logic        fmt_sm;
    logic [13:0] lin_in;
    logic [7:0]  pcm_in;
    logic        out_valid;
    logic [7:0]  pcm_out;
    logic [13:0] lin_out;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] last_pcm = '0;
    int last_lin = 0;

    always #5 clk = ~clk;

    g711_codec u_g711_codec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .law_a     (law_a),
        .fmt_sm    (fmt_sm),
        .lin_in    (lin_in),
        .pcm_in    (pcm_in),
        .out_valid (out_valid),
        .pcm_out   (pcm_out),
        .lin_out   (lin_out)
    );

    function automatic logic [7:0] fmt_mask(bit la, bit sm);
        if (sm) return 8'h00;
        return la ? 8'h55 : 8'h7F;
    endfunction

    function automatic logic [7:0] ref_encode(int x, bit la, bit sm);
        int  mag, seg, step, xa;
        bit  pos;
        pos = (x >= 0);
        if (!la) begin
            mag = pos ? x : -x;
            if (mag > 8158) mag = 8158;
            mag = mag + 33;
            seg = 0;
            while (seg < 7 && mag >= (64 << seg)) seg++;
            step = (mag >> (seg + 1)) & 15;
        end else begin
            xa  = x >>> 1;
            mag = pos ? xa : (-xa - 1);
            if (mag < 32) begin
                seg  = 0;
                step = (mag >> 1) & 15;
            end else begin
                seg = 1;
                while (seg < 7 && mag >= (32 << seg)) seg++;
                step = (mag >> seg) & 15;
            end
        end
        return {pos, 3'(seg), 4'(step)} ^ fmt_mask(la, sm);
    endfunction

    function automatic int ref_decode(logic [7:0] pc, bit la, bit sm);
        logic [7:0] c;
        int seg, step, mag;
        c    = pc ^ fmt_mask(la, sm);
        seg  = int'(c[6:4]);
        step = int'(c[3:0]);
        if (!la) mag = ((2 * step + 33) << seg) - 33;
        else if (seg == 0) mag = 2 * (2 * step + 1);
        else mag = 2 * ((2 * step + 33) << (seg - 1));
        return c[7] ? mag : -mag;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int x, input logic [7:0] pc, input bit la, input bit sm,
                         input string etag, input string dtag);
        lin_in   = 14'(x);
        pcm_in   = pc;
        law_a    = la;
        fmt_sm   = sm;
        in_valid = 1'b1;
        @(negedge clk);
        last_pcm = ref_encode(x, la, sm);
        last_lin = ref_decode(pc, la, sm);
        chk("R2 out_valid after strobe", int'(out_valid), 1);
        chk(etag, int'(pcm_out), int'(last_pcm));
        chk(dtag, int'($signed(lin_out)), last_lin);
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0;
        lin_in   = 14'($urandom);
        pcm_in   = 8'($urandom);
        law_a    = 1'($urandom);
        fmt_sm   = 1'($urandom);
        @(negedge clk);
        chk("R2 out_valid low when idle", int'(out_valid), 0);
        chk("R2 pcm_out held", int'(pcm_out), int'(last_pcm));
        chk("R2 lin_out held", int'($signed(lin_out)), last_lin);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0DEC5));
        rst_n = 1'b0; in_valid = 1'b0; law_a = 1'b0; fmt_sm = 1'b0;
        lin_in = 14'h1ABC; pcm_in = 8'hA5;
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 pcm_out in reset", int'(pcm_out), 0);
        chk("R1 lin_out in reset", int'(lin_out), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R3 sign/magnitude corner codes
        apply(8191,  8'hFF, 1'b0, 1'b1, "R3 mu +full", "R9 mu decode +full");
        apply(0,     8'h80, 1'b0, 1'b1, "R3 mu +zero", "R11 mu +zero decode");
        apply(-1,    8'h00, 1'b1, 1'b1, "R3 A -zero",  "R11 A -zero decode");
        apply(-8192, 8'h7F, 1'b1, 1'b1, "R3 A -full",  "R10 A decode -full");
        // R4 mu CCITT corners
        apply(0,     8'hFF, 1'b0, 1'b0, "R4 mu +zero", "R11 mu CCITT +zero decode");
        apply(8191,  8'h7F, 1'b0, 1'b0, "R4 mu +full", "R11 mu CCITT -zero decode");
        apply(-8192, 8'h00, 1'b0, 1'b0, "R4 mu -full", "R9 mu CCITT -full decode");
        // R5 A CCITT corners
        apply(0,     8'hD5, 1'b1, 1'b0, "R5 A +zero", "R11 A CCITT +zero decode");
        apply(-1,    8'h55, 1'b1, 1'b0, "R5 A -zero", "R11 A CCITT -zero decode");
        apply(8191,  8'hAA, 1'b1, 1'b0, "R5 A +full", "R10 A CCITT +full decode");
        apply(-8192, 8'h2A, 1'b1, 1'b0, "R5 A -full", "R10 A CCITT -full decode");
        idle_cycle();
        // R8 saturation edges
        apply(8158,  8'h12, 1'b0, 1'b1, "R8 mu at clip", "R9 mu decode");
        apply(8159,  8'h93, 1'b0, 1'b1, "R8 mu above clip", "R9 mu decode");
        apply(-8159, 8'h45, 1'b0, 1'b1, "R8 mu below -clip", "R9 mu decode");
        apply(-8192, 8'hC7, 1'b0, 1'b1, "R8 mu min input", "R9 mu decode");
        // R6 / R7 segment boundaries
        apply(30,    8'h10, 1'b0, 1'b1, "R6 mu seg edge", "R9 mu decode");
        apply(31,    8'h1F, 1'b0, 1'b1, "R6 mu seg edge", "R9 mu decode");
        apply(63,    8'h20, 1'b1, 1'b1, "R7 A seg edge", "R10 A decode");
        apply(64,    8'h9F, 1'b1, 1'b1, "R7 A seg edge", "R10 A decode");
        apply(-65,   8'h01, 1'b1, 1'b1, "R7 A neg seg edge", "R10 A decode");
        idle_cycle();
        idle_cycle();

        for (int n = 0; n < 3000; n++) begin
            bit          la, sm;
            int          x;
            logic [13:0] t;
            la = 1'($urandom);
            sm = 1'($urandom);
            t  = 14'($urandom);
            x  = int'($signed(t));
            if ($urandom_range(0, 15) == 0) x = ($urandom_range(0, 1) == 1) ? 8191 : -8192;
            if ($urandom_range(0, 7) == 0)  x = int'($urandom_range(0, 80)) - 40;
            apply(x, 8'($urandom), la, sm,
                  la ? (sm ? "R7 A encode" : "R5 A CCITT encode")
                     : (sm ? "R6 mu encode" : "R4 mu CCITT encode"),
                  la ? "R10 A decode" : "R9 mu decode");
            if ($urandom_range(0, 7) == 0) idle_cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule